// File: doc/BRIEF.md
# Criticality-Aware Two-Level Slot Arbiter

This block shares one resource, such as a cache port or a memory bus, among tasks that belong to three criticality classes (class 2 highest, class 0 lowest). Arbitration happens once per slot and uses two separate weighted schedules. An inter-class schedule decides which class owns the slot. An intra-class schedule then decides which task of that class is served. Each class has a weight, which is the number of class turns it gets per round. Each class also has a window, which is the number of consecutive task slots that make up one class turn. Each task has a weight, which is the number of consecutive turns it keeps inside its class rotation.

Slots are never wasted. A slot whose scheduled task is idle goes to another requesting task. A slot left free by a zero task weight goes first to a task of another class. Two configuration banks are held: a primary one and an alternate one. Per-class overrun inputs select the re-arbitration level. The first level moves the arbiter onto the alternate bank. The second level also drops the lowest class from the schedule, so that class is served only when no higher class is requesting. Every change of configuration or mode is applied at a round boundary.

Top module: `slot_arbiter`

## Requirements
- R1: After reset there is no grant, the mode reads normal (activeMode = 0), no starvation flag is raised, and both banks hold weight 1 for every class and task. Primary windows are 1, 1, 1 and alternate windows are 1, 2, 2 for classes 0, 1, 2.
- R2: A grant is presented for exactly one cycle, in the cycle after the clock edge that samples slotStart. At that time gntOneHot has exactly the bit gntIdx set, where task t of class c has index c*TASKS_PER_CLASS+t. Without slotStart the grant outputs are all zero.
- R3: A round visits the classes in order from class 2 down to class 0. Each class receives weight × window consecutive slots, and a window of 0 acts as 1.
- R4: Within a class, tasks take turns in ascending index order. A task of weight w is scheduled for w consecutive owned slots. The rotation position carries across class turns and is reset to task 0 at each round boundary.
- R5: A task of weight 0 occupies one position in the rotation, and that position is a free slot. A free slot goes to the first requesting task of another class, scanning classes from highest to lowest and tasks in ascending order. Only if no other class is requesting does it go to a requesting task of its own class.
- R6: If the scheduled task is not requesting, the slot goes to the first requesting task in a scan from class 2 down to class 0, ascending task index within each class.
- R7: When no task is requesting at slotStart, no grant is issued.
- R8: A class of weight 0 gets no scheduled slots and raises its starveFlag bit while that configuration is active. If all weights are 0, each slot is served only by the scan of R6.
- R9: Configuration writes go to the bank chosen by cfgBank. Addresses are: class c weight at c, class c window at 3+c, and the weight of task t of class c at 6+c*TASKS_PER_CLASS+t. A write has no effect on the round in progress.
- R10: If some ovrAlt bit is high at the slot that ends a round, and no ovrPrio bit is high, the next round uses the alternate bank and activeMode reads 1.
- R11: If some ovrPrio bit is high at the slot that ends a round, the next round uses the alternate bank with class 0 removed from the schedule, and activeMode reads 2. In this mode class 0 is granted only when no task of classes 1 and 2 is requesting.
- R12: The mode changes only at a round boundary. It returns to normal with the primary bank once all overrun inputs are low at the round end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slotStart | input | 1 | Starts one arbitration slot |
| reqVec | input | NUM_TASKS | Per-task request, index c*TASKS_PER_CLASS+t |
| cfgWe | input | 1 | Configuration write strobe |
| cfgBank | input | 1 | Bank written: 0 primary, 1 alternate |
| cfgAddr | input | ADDR_W | Configuration entry address |
| cfgData | input | WEIGHT_W | Value written |
| ovrAlt | input | 3 | Per-class overrun, first level |
| ovrPrio | input | 3 | Per-class overrun, second level |
| gntValid | output | 1 | Grant issued for the last slot |
| gntOneHot | output | NUM_TASKS | One-hot granted task |
| gntIdx | output | IDX_W | Granted task index |
| activeMode | output | 2 | 0 normal, 1 alternate, 2 prioritized |
| starveFlag | output | 3 | Active class weight is zero |

## Verification
The hardest case to reach is a configuration write or an overrun change that lands in the middle of a round. The change has to stay invisible until the round ends, and it must then take effect with the rotation positions cleared. The bench drives this through a swept series of weight and window writes issued between slots, with no regard to round alignment. Its reference model holds staged and active copies of the configuration and rebuilds the expected round order only when the last slot of a round is consumed. Free slots and idle owners come up often under request patterns drawn from an LFSR. Those patterns include all-idle vectors, vectors with only class 0 requesting, and mixed vectors, and they are applied in all three modes.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;
  localparam int NUM_CLASSES = 3;
  localparam int CLS_W = 2;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_ALT    = 2'd1,
    MODE_PRIO   = 2'd2
  } arbMode_e;

  // strobes from the slot sequencer to the datapath
  typedef struct packed {
    logic             slotGo;
    logic             roundEnd;
    logic             ownerValid;
    logic             ownerFree;
    logic [CLS_W-1:0] ownerCls;
    arbMode_e         mode;
    arbMode_e         nextMode;
  } seqStrobe_t;
endpackage

// File: rtl/arb_datapath.sv
module arb_datapath
  import slot_arb_pkg::*;
#(
  parameter int TASKS = 2,
  parameter int WW = 3,
  parameter int AW = 4,
  parameter int TW = 1,
  parameter int GW = 3,
  localparam int NT = NUM_CLASSES * TASKS
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWe,
  input  logic                   cfgBank,
  input  logic [AW-1:0]          cfgAddr,
  input  logic [WW-1:0]          cfgData,
  input  seqStrobe_t             st,
  input  logic [TW-1:0]          ownerTask,
  input  logic [NT-1:0]          reqVec,
  output logic [WW-1:0]          actCw [NUM_CLASSES],
  output logic [WW-1:0]          actZ  [NUM_CLASSES],
  output logic [WW-1:0]          actTw [NT],
  output logic [NUM_CLASSES-1:0] starve,
  output logic                   gntValid,
  output logic [NT-1:0]          gntOneHot,
  output logic [GW-1:0]          gntIdx
);
  logic [WW-1:0] bankCw [2][NUM_CLASSES];
  logic [WW-1:0] bankZ  [2][NUM_CLASSES];
  logic [WW-1:0] bankTw [2][NT];
  logic          loadSel;
  logic [NT-1:0] effReq;
  logic          pickHit;
  logic [GW-1:0] pickIdx;
  logic          skipOwn;
  int            ownerG;

  // staged configuration banks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < 2; b++) begin
        for (int c = 0; c < NUM_CLASSES; c++) begin
          bankCw[b][c] <= WW'(1);
          bankZ[b][c]  <= (b == 1 && c != 0) ? WW'(2) : WW'(1);
        end
        for (int t = 0; t < NT; t++) bankTw[b][t] <= WW'(1);
      end
    end else if (cfgWe) begin
      for (int c = 0; c < NUM_CLASSES; c++) begin
        if (cfgAddr == AW'(c)) bankCw[cfgBank][c] <= cfgData;
        if (cfgAddr == AW'(NUM_CLASSES + c)) bankZ[cfgBank][c] <= cfgData;
      end
      for (int t = 0; t < NT; t++)
        if (cfgAddr == AW'(2 * NUM_CLASSES + t)) bankTw[cfgBank][t] <= cfgData;
    end
  end

  // active copy, swapped only at a round boundary
  assign loadSel = (st.nextMode != MODE_NORMAL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CLASSES; c++) begin
        actCw[c] <= WW'(1);
        actZ[c]  <= WW'(1);
      end
      for (int t = 0; t < NT; t++) actTw[t] <= WW'(1);
    end else if (st.slotGo && st.roundEnd) begin
      for (int c = 0; c < NUM_CLASSES; c++) begin
        actCw[c] <= bankCw[loadSel][c];
        actZ[c]  <= bankZ[loadSel][c];
      end
      for (int t = 0; t < NT; t++) actTw[t] <= bankTw[loadSel][t];
    end
  end

  always_comb
    for (int c = 0; c < NUM_CLASSES; c++) starve[c] = (actCw[c] == '0);

  // grant selection: scheduled owner, else scan from the highest class
  always_comb begin
    effReq = reqVec;
    if (st.mode == MODE_PRIO && (|reqVec[NT-1:TASKS])) effReq[TASKS-1:0] = '0;
    ownerG  = int'(st.ownerCls) * TASKS + int'(ownerTask);
    skipOwn = st.ownerValid && st.ownerFree;
    pickHit = 1'b0;
    pickIdx = '0;
    if (st.ownerValid && !st.ownerFree && effReq[ownerG]) begin
      pickHit = 1'b1;
      pickIdx = GW'(ownerG);
    end else begin
      for (int c = NUM_CLASSES - 1; c >= 0; c--)
        for (int t = 0; t < TASKS; t++)
          if (!pickHit && !(skipOwn && c == int'(st.ownerCls)) && effReq[c*TASKS+t]) begin
            pickHit = 1'b1;
            pickIdx = GW'(c * TASKS + t);
          end
      if (skipOwn)
        for (int t = 0; t < TASKS; t++)
          if (!pickHit && effReq[int'(st.ownerCls)*TASKS+t]) begin
            pickHit = 1'b1;
            pickIdx = GW'(int'(st.ownerCls) * TASKS + t);
          end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gntValid  <= 1'b0;
      gntOneHot <= '0;
      gntIdx    <= '0;
    end else if (st.slotGo && pickHit) begin
      gntValid  <= 1'b1;
      gntOneHot <= NT'(1) << pickIdx;
      gntIdx    <= pickIdx;
    end else begin
      gntValid  <= 1'b0;
      gntOneHot <= '0;
    end
  end

  // R9: the active configuration only moves at a round boundary
  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_holdChk
    a_r9_active_hold: assert property (@(posedge clk) disable iff (!rstN)
      !$past(st.slotGo && st.roundEnd) |-> ($stable(actCw[c]) && $stable(actZ[c])));
  end
endmodule

// File: rtl/arb_seq.sv
module arb_seq
  import slot_arb_pkg::*;
#(
  parameter int TASKS = 2,
  parameter int WW = 3,
  parameter int TW = 1,
  localparam int NT = NUM_CLASSES * TASKS
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   slotStart,
  input  logic [NUM_CLASSES-1:0] ovrAlt,
  input  logic [NUM_CLASSES-1:0] ovrPrio,
  input  logic [WW-1:0]          actCw [NUM_CLASSES],
  input  logic [WW-1:0]          actZ  [NUM_CLASSES],
  input  logic [WW-1:0]          actTw [NT],
  output seqStrobe_t             st,
  output logic [TW-1:0]          ownerTask
);
  arbMode_e         mode, nextMode;
  logic [CLS_W-1:0] clsPtr, curCls;
  logic [WW-1:0]    clsRep, winCnt;
  logic [TW-1:0]    tPtr [NUM_CLASSES];
  logic [WW-1:0]    tRep [NUM_CLASSES];
  logic [WW-1:0]    effW [NUM_CLASSES];
  logic [WW-1:0]    zSpan, wCur, tSpan;
  logic             found, lowerExists, lastWin, lastRep, lastTurn, ownerFree, roundEnd;

  always_comb begin
    for (int c = 0; c < NUM_CLASSES; c++)
      effW[c] = (mode == MODE_PRIO && c == 0) ? '0 : actCw[c];
    found  = 1'b0;
    curCls = '0;
    for (int c = 0; c < NUM_CLASSES; c++)
      if (c <= int'(clsPtr) && effW[c] != '0) begin
        found  = 1'b1;
        curCls = CLS_W'(c);
      end
    lowerExists = 1'b0;
    for (int c = 0; c < NUM_CLASSES; c++)
      if (c < int'(curCls) && effW[c] != '0) lowerExists = 1'b1;
    zSpan     = (actZ[curCls] == '0) ? WW'(1) : actZ[curCls];
    lastWin   = (winCnt == zSpan - WW'(1));
    lastRep   = (clsRep == effW[curCls] - WW'(1));
    wCur      = actTw[int'(curCls)*TASKS + int'(tPtr[curCls])];
    ownerFree = (wCur == '0);
    tSpan     = ownerFree ? WW'(1) : wCur;
    lastTurn  = (tRep[curCls] == tSpan - WW'(1));
    roundEnd  = !found || (lastWin && lastRep && !lowerExists);
    if (|ovrPrio)     nextMode = MODE_PRIO;
    else if (|ovrAlt) nextMode = MODE_ALT;
    else              nextMode = MODE_NORMAL;
  end

  assign st.slotGo     = slotStart;
  assign st.roundEnd   = roundEnd;
  assign st.ownerValid = found;
  assign st.ownerFree  = ownerFree;
  assign st.ownerCls   = curCls;
  assign st.mode       = mode;
  assign st.nextMode   = nextMode;
  assign ownerTask     = tPtr[curCls];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode   <= MODE_NORMAL;
      clsPtr <= CLS_W'(NUM_CLASSES - 1);
      clsRep <= '0;
      winCnt <= '0;
      for (int c = 0; c < NUM_CLASSES; c++) begin
        tPtr[c] <= '0;
        tRep[c] <= '0;
      end
    end else if (slotStart) begin
      if (roundEnd) begin
        mode   <= nextMode;
        clsPtr <= CLS_W'(NUM_CLASSES - 1);
        clsRep <= '0;
        winCnt <= '0;
        for (int c = 0; c < NUM_CLASSES; c++) begin
          tPtr[c] <= '0;
          tRep[c] <= '0;
        end
      end else begin
        if (lastTurn) begin
          tRep[curCls] <= '0;
          tPtr[curCls] <= (tPtr[curCls] == TW'(TASKS - 1)) ? '0 : tPtr[curCls] + TW'(1);
        end else begin
          tRep[curCls] <= tRep[curCls] + WW'(1);
        end
        if (lastWin && lastRep) begin
          clsPtr <= curCls - CLS_W'(1);
          clsRep <= '0;
          winCnt <= '0;
        end else if (lastWin) begin
          clsRep <= clsRep + WW'(1);
          winCnt <= '0;
        end else begin
          winCnt <= winCnt + WW'(1);
        end
      end
    end
  end

  // R12: mode register moves only on a round-ending slot
  a_r12_mode_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    !$past(slotStart && roundEnd) |-> $stable(mode));
  // R11: prioritized mode never schedules class 0
  a_r11_no_low_owner: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_PRIO && found) |-> (curCls != '0));
  // R3: window counter stays inside the owner's window
  a_r3_window_range: assert property (@(posedge clk) disable iff (!rstN)
    found |-> (winCnt < zSpan));
endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter
  import slot_arb_pkg::*;
#(
  parameter int TASKS_PER_CLASS = 2,
  parameter int WEIGHT_W = 3,
  localparam int NUM_TASKS = NUM_CLASSES * TASKS_PER_CLASS,
  localparam int IDX_W = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1,
  localparam int TASK_W = (TASKS_PER_CLASS > 1) ? $clog2(TASKS_PER_CLASS) : 1,
  localparam int CFG_ENTRIES = 2 * NUM_CLASSES + NUM_TASKS,
  localparam int ADDR_W = $clog2(CFG_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   slotStart,
  input  logic [NUM_TASKS-1:0]   reqVec,
  input  logic                   cfgWe,
  input  logic                   cfgBank,
  input  logic [ADDR_W-1:0]      cfgAddr,
  input  logic [WEIGHT_W-1:0]    cfgData,
  input  logic [NUM_CLASSES-1:0] ovrAlt,
  input  logic [NUM_CLASSES-1:0] ovrPrio,
  output logic                   gntValid,
  output logic [NUM_TASKS-1:0]   gntOneHot,
  output logic [IDX_W-1:0]       gntIdx,
  output logic [1:0]             activeMode,
  output logic [NUM_CLASSES-1:0] starveFlag
);
  seqStrobe_t          st;
  logic [TASK_W-1:0]   ownerTask;
  logic [WEIGHT_W-1:0] actCw [NUM_CLASSES];
  logic [WEIGHT_W-1:0] actZ  [NUM_CLASSES];
  logic [WEIGHT_W-1:0] actTw [NUM_TASKS];

  arb_seq #(.TASKS(TASKS_PER_CLASS), .WW(WEIGHT_W), .TW(TASK_W)) i_seq (
    .clk(clk), .rstN(rstN), .slotStart(slotStart),
    .ovrAlt(ovrAlt), .ovrPrio(ovrPrio),
    .actCw(actCw), .actZ(actZ), .actTw(actTw),
    .st(st), .ownerTask(ownerTask)
  );

  arb_datapath #(.TASKS(TASKS_PER_CLASS), .WW(WEIGHT_W), .AW(ADDR_W),
                 .TW(TASK_W), .GW(IDX_W)) i_dp (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgBank(cfgBank), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .st(st), .ownerTask(ownerTask), .reqVec(reqVec),
    .actCw(actCw), .actZ(actZ), .actTw(actTw), .starve(starveFlag),
    .gntValid(gntValid), .gntOneHot(gntOneHot), .gntIdx(gntIdx)
  );

  assign activeMode = st.mode;

  a_r2_onehot_grant: assert property (@(posedge clk) disable iff (!rstN)
    gntValid |-> ($onehot(gntOneHot) && gntOneHot[gntIdx]));
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !$past(slotStart) |-> (!gntValid && gntOneHot == '0));
  a_r2_grant_requested: assert property (@(posedge clk) disable iff (!rstN)
    gntValid |-> (($past(reqVec) & gntOneHot) != '0));
  a_r6_work_conserving: assert property (@(posedge clk) disable iff (!rstN)
    $past(slotStart && (reqVec != '0)) |-> gntValid);
  a_r11_low_only_idle: assert property (@(posedge clk) disable iff (!rstN)
    (gntValid && gntIdx < IDX_W'(TASKS_PER_CLASS) && $past(st.mode == MODE_PRIO))
      |-> ($past(reqVec[NUM_TASKS-1:TASKS_PER_CLASS]) == '0));
endmodule

// File: tb/test_slot_arbiter.sv
module test_slot_arbiter;
  localparam int T = 2;
  localparam int NT = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       slotStart = 1'b0;
  logic [5:0] reqVec = '0;
  logic       cfgWe = 1'b0;
  logic       cfgBank = 1'b0;
  logic [3:0] cfgAddr = '0;
  logic [2:0] cfgData = '0;
  logic [2:0] ovrAlt = '0;
  logic [2:0] ovrPrio = '0;
  logic       gntValid;
  logic [5:0] gntOneHot;
  logic [2:0] gntIdx;
  logic [1:0] activeMode;
  logic [2:0] starveFlag;

  slot_arbiter i_slot_arbiter (
    .clk(clk), .rstN(rstN), .slotStart(slotStart), .reqVec(reqVec),
    .cfgWe(cfgWe), .cfgBank(cfgBank), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .ovrAlt(ovrAlt), .ovrPrio(ovrPrio),
    .gntValid(gntValid), .gntOneHot(gntOneHot), .gntIdx(gntIdx),
    .activeMode(activeMode), .starveFlag(starveFlag)
  );

  always #10 clk = ~clk;

  int nVec = 0;
  int nFail = 0;
  int mCw [2][3];
  int mZ [2][3];
  int mTw [2][6];
  int aCw [3];
  int aZ [3];
  int aTw [6];
  int aMode = 0;
  int ownList [256];
  int len = 0;
  int pos = 0;
  int tPtr [3];
  int tRep [3];
  bit pendWrite = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    nVec++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void buildRound();
    int b;
    int nm;
    nm = (ovrPrio != 0) ? 2 : ((ovrAlt != 0) ? 1 : 0);
    b = (nm != 0) ? 1 : 0;
    aMode = nm;
    for (int c = 0; c < 3; c++) begin
      aCw[c] = mCw[b][c];
      aZ[c] = mZ[b][c];
      tPtr[c] = 0;
      tRep[c] = 0;
    end
    for (int g = 0; g < NT; g++) aTw[g] = mTw[b][g];
    len = 0;
    for (int c = 2; c >= 0; c--) begin
      int ew;
      ew = (aMode == 2 && c == 0) ? 0 : aCw[c];
      for (int r = 0; r < ew; r++)
        for (int z = 0; z < ((aZ[c] == 0) ? 1 : aZ[c]); z++) begin
          ownList[len] = c;
          len++;
        end
    end
    if (len == 0) begin
      ownList[0] = -1;
      len = 1;
    end
    pos = 0;
    pendWrite = 0;
  endfunction

  function automatic int pickExp(logic [5:0] r, int own, int t, bit free);
    logic [5:0] e;
    e = r;
    if (aMode == 2 && r[5:2] != 0) e[1:0] = 2'b00;
    if (own >= 0 && !free && e[own*T+t]) return own * T + t;
    for (int c = 2; c >= 0; c--)
      for (int k = 0; k < T; k++)
        if (!(own >= 0 && free && c == own) && e[c*T+k]) return c * T + k;
    if (own >= 0 && free)
      for (int k = 0; k < T; k++)
        if (e[own*T+k]) return own * T + k;
    return -1;
  endfunction

  function automatic logic [5:0] nextReq();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (lfsr[9:8])
      2'd0: return lfsr[5:0];
      2'd1: return lfsr[5:0] & lfsr[15:10];
      2'd2: return lfsr[7] ? 6'h3f : 6'h00;
      default: return {4'b0000, lfsr[1:0]} | (lfsr[6] ? 6'h00 : {lfsr[13:10], 2'b00});
    endcase
  endfunction

  task automatic wrCfg(int bank, int addr, int data);
    @(negedge clk);
    cfgWe = 1'b1;
    cfgBank = bank[0];
    cfgAddr = addr[3:0];
    cfgData = data[2:0];
    @(negedge clk);
    cfgWe = 1'b0;
    if (addr < 3) mCw[bank][addr] = data;
    else if (addr < 6) mZ[bank][addr-3] = data;
    else mTw[bank][addr-6] = data;
    pendWrite = 1;
  endtask

  task automatic doSlot(logic [5:0] r);
    int own;
    int t;
    bit free;
    int exp;
    string tag;
    own = ownList[pos];
    t = 0;
    free = 0;
    if (own >= 0) begin
      int w;
      int span;
      t = tPtr[own];
      w = aTw[own*T+t];
      free = (w == 0);
      span = free ? 1 : w;
      if (tRep[own] == span - 1) begin
        tRep[own] = 0;
        tPtr[own] = (t + 1) % T;
      end else tRep[own]++;
    end
    exp = pickExp(r, own, t, free);
    if (r == 0) tag = "R7";
    else if (own < 0) tag = "R8";
    else if (free) tag = "R5";
    else if (!r[own*T+t]) tag = "R6";
    else if (aMode == 2) tag = "R11";
    else if (aMode == 1) tag = "R10";
    else if (pendWrite) tag = "R9";
    else if (t != 0) tag = "R4";
    else tag = "R3";
    @(negedge clk);
    reqVec = r;
    slotStart = 1'b1;
    @(negedge clk);
    slotStart = 1'b0;
    chk(gntValid == (exp >= 0), tag, "gntValid", int'(gntValid), int'(exp >= 0));
    if (exp >= 0) begin
      chk(int'(gntIdx) == exp, tag, "gntIdx", int'(gntIdx), exp);
      chk(gntOneHot == (6'd1 << exp), tag, "gntOneHot", int'(gntOneHot), 1 << exp);
    end else begin
      chk(gntOneHot == 0, tag, "gntOneHot", int'(gntOneHot), 0);
    end
    pos++;
    if (pos == len) buildRound();
    chk(int'(activeMode) == aMode, "R12", "activeMode", int'(activeMode), aMode);
    for (int c = 0; c < 3; c++)
      chk(starveFlag[c] == (aCw[c] == 0), "R8", "starveFlag", int'(starveFlag[c]), int'(aCw[c] == 0));
    @(negedge clk);
    chk(!gntValid && gntOneHot == 0, "R2", "idle grant", int'(gntValid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2; b++) begin
      for (int c = 0; c < 3; c++) begin
        mCw[b][c] = 1;
        mZ[b][c] = (b == 1 && c != 0) ? 2 : 1;
      end
      for (int g = 0; g < NT; g++) mTw[b][g] = 1;
    end
    buildRound();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!gntValid, "R1", "gntValid", int'(gntValid), 0);
    chk(gntOneHot == 0, "R1", "gntOneHot", int'(gntOneHot), 0);
    chk(activeMode == 0, "R1", "activeMode", int'(activeMode), 0);
    chk(starveFlag == 0, "R1", "starveFlag", int'(starveFlag), 0);

    // default round, all requesting, then mixed patterns (R3 R4 R6 R7)
    repeat (12) doSlot(6'h3f);
    doSlot(6'h00);
    repeat (24) doSlot(nextReq());

    // sweep class-1 weight, class-2 window, class-1 task-0 weight (R5 R8 R9)
    wrCfg(0, 6 + 1, 2);
    for (int a = 0; a < 3; a++)
      for (int z = 1; z < 4; z++)
        for (int w = 0; w < 3; w++) begin
          wrCfg(0, 1, a);
          wrCfg(0, 5, z);
          wrCfg(0, 6 + 2, w);
          repeat (12) doSlot(nextReq());
          doSlot(6'h3f);
        end

    // every class weight zero (R8)
    wrCfg(0, 0, 0);
    wrCfg(0, 1, 0);
    wrCfg(0, 2, 0);
    repeat (10) doSlot(nextReq());
    wrCfg(0, 0, 1);
    wrCfg(0, 1, 2);
    wrCfg(0, 2, 1);

    // first overrun level: alternate bank (R10)
    ovrAlt = 3'b010;
    repeat (30) doSlot(nextReq());
    wrCfg(1, 6 + 4, 3);
    wrCfg(1, 2, 2);
    repeat (30) doSlot(nextReq());

    // second overrun level: prioritized (R11)
    ovrPrio = 3'b100;
    repeat (20) doSlot(6'b000011);
    repeat (20) doSlot(6'b100011);
    repeat (40) doSlot(nextReq());

    // overrun cleared: back to normal (R12)
    ovrPrio = 3'b000;
    ovrAlt = 3'b000;
    repeat (40) doSlot(nextReq());

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end
endmodule